// File: doc/BRIEF.md
# Hexadecimal Object Record Loader

This block takes a stream of 8-bit ASCII characters, one for each cycle in which the character is valid, and parses them as hexadecimal object records. A record is framed by a leading colon. The colon is followed by a byte count, a 16-bit load address, a record kind and the payload bytes. A closing checksum ends the record. Every payload byte of a data record goes straight to a memory write port as one write.

The loader also reports a correctly checksummed end-of-file record on a sticky `done` output. It raises a sticky `error` output when it sees a malformed character, an unknown record kind or a wrong checksum. The block always accepts input, so the upstream source never stalls. Both flags stay set until a synchronous reset.

Top module: `hex_record_loader`

## Requirements
- R1: A synchronous, active-high reset clears `done`, `error` and `wr_en`, and returns the parser to waiting for a colon.
- R2: `in_ready` is always 1. A character is consumed on every clock edge where `in_valid` is 1. Cycles with `in_valid` at 0 change nothing.
- R3: A record is the colon (0x3A), then 2 hex characters for the byte count, 4 hex characters for the address with the most significant nibble first, 2 hex characters for the kind, 2 hex characters per payload byte with the high nibble first, and 2 hex characters for the checksum.
- R4: Hex digits are 0-9, A-F and a-f. Any other character inside a record, including a second colon, sets `error` and returns the parser to waiting for a colon.
- R5: In a data record (kind 0x00), payload byte i is written to load address plus i, wrapping modulo 65536. Each write is a `wr_en` pulse of exactly one cycle. The pulse comes in the cycle after the edge that takes the byte's second character.
- R6: The 8-bit sum of the count byte, both address bytes, the kind byte, all payload bytes and the checksum byte must be zero. If it is not, `error` rises in the cycle after the checksum's second character.
- R7: A kind other than 0x00 or 0x01 sets `error` once its second character is taken, and the rest of the record is abandoned.
- R8: An end-of-file record (kind 0x01) with a good checksum sets `done`, which holds until reset. Payload bytes of such a record are never written.
- R9: Carriage return (0x0D) and line feed (0x0A) between records are skipped. Any other non-colon character between records sets `error`.
- R10: `error` is sticky until reset. Parsing and writing go on normally from the next colon.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character on `in_char` is valid this cycle |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Always high; the block accepts a character every cycle |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| done | output | 1 | Sticky: a good end-of-file record was seen |
| error | output | 1 | Sticky: bad character, bad kind or checksum mismatch |

## Verification
Two functions can fall in the same cycle. First, the write pulse for the last payload byte appears while the first checksum character is already being taken. Second, write pulses of a later good record can appear while the sticky error from an earlier bad record is still high. The bench provokes both with back-to-back characters and no gaps, and by following a corrupted record at once with a clean one. A behavioural reference model predicts the strobe, address, data and both flags for every cycle and compares them against the outputs. A mistaken interaction, such as the error flag suppressing writes or a dropped final write, shows up as a mismatch in the exact cycle where it happens.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int ACC_W   = ADDR_W - NIB_W;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    localparam logic [DATA_W-1:0] KIND_DATA = 8'h00;
    localparam logic [DATA_W-1:0] KIND_EOF  = 8'h01;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_COUNT,
        PH_ADDR,
        PH_KIND,
        PH_PAYLOAD,
        PH_CHECK
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [1:0]          nib_cnt;
        logic [ACC_W-1:0]    acc;
        logic [DATA_W-1:0]   remain;
        logic [ADDR_W-1:0]   cur_addr;
        logic [DATA_W-1:0]   kind;
        logic [DATA_W-1:0]   sum;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
        logic                done;
        logic                err;
    } parse_s;
endpackage

// File: rtl/hexrec_char_class.sv
module hexrec_char_class
    import hexrec_pkg::*;
(
    input  logic [7:0]       ch,
    output logic [NIB_W-1:0] nib,
    output logic             is_hex,
    output logic             is_colon,
    output logic             is_eol
);
    always_comb begin
        nib    = '0;
        is_hex = 1'b0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            nib    = ch[3:0];
            is_hex = 1'b1;
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            nib    = ch[3:0] + 4'd9;
            is_hex = 1'b1;
        end
        is_colon = (ch == CH_COLON);
        is_eol   = (ch == CH_CR) || (ch == CH_LF);
    end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [NIB_W-1:0]  nib,
    input  logic              is_hex,
    input  logic              is_colon,
    input  logic              is_eol,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    parse_s q, d;

    logic [DATA_W-1:0] byte_v;
    logic [DATA_W-1:0] sum_nx;
    logic              byte_done;
    logic              field_done;

    always_comb begin
        byte_v     = {q.acc[NIB_W-1:0], nib};
        sum_nx     = q.sum + byte_v;
        byte_done  = q.nib_cnt[0];
        field_done = (q.phase == PH_ADDR) ? (q.nib_cnt == 2'd3) : byte_done;

        d       = q;
        d.wr_en = 1'b0;

        if (take) begin
            if (q.phase == PH_WAIT) begin
                if (is_colon) begin
                    d.phase   = PH_COUNT;
                    d.nib_cnt = '0;
                    d.sum     = '0;
                end else if (!is_eol) begin
                    d.err = 1'b1;
                end
            end else if (!is_hex) begin
                d.err   = 1'b1;
                d.phase = PH_WAIT;
            end else begin
                d.acc     = {q.acc[ACC_W-NIB_W-1:0], nib};
                d.nib_cnt = q.nib_cnt + 2'd1;
                if (byte_done) begin
                    d.sum = sum_nx;
                end
                if (field_done) begin
                    d.nib_cnt = '0;
                    unique case (q.phase)
                        PH_COUNT: begin
                            d.remain = byte_v;
                            d.phase  = PH_ADDR;
                        end
                        PH_ADDR: begin
                            d.cur_addr = {q.acc, nib};
                            d.phase    = PH_KIND;
                        end
                        PH_KIND: begin
                            d.kind = byte_v;
                            if (byte_v != KIND_DATA && byte_v != KIND_EOF) begin
                                d.err   = 1'b1;
                                d.phase = PH_WAIT;
                            end else if (q.remain == '0) begin
                                d.phase = PH_CHECK;
                            end else begin
                                d.phase = PH_PAYLOAD;
                            end
                        end
                        PH_PAYLOAD: begin
                            if (q.kind == KIND_DATA) begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.cur_addr;
                                d.wr_data = byte_v;
                            end
                            d.cur_addr = q.cur_addr + 1'b1;
                            d.remain   = q.remain - 1'b1;
                            if (q.remain == 8'd1) begin
                                d.phase = PH_CHECK;
                            end
                        end
                        PH_CHECK: begin
                            if (sum_nx != '0) begin
                                d.err = 1'b1;
                            end else if (q.kind == KIND_EOF) begin
                                d.done = 1'b1;
                            end
                            d.phase = PH_WAIT;
                        end
                        default: d.phase = PH_WAIT;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{phase: PH_WAIT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign done    = q.done;
    assign err     = q.err;
endmodule

// File: rtl/hex_record_loader.sv
module hex_record_loader
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              error
);
    logic [NIB_W-1:0] nib;
    logic             is_hex;
    logic             is_colon;
    logic             is_eol;

    assign in_ready = 1'b1;

    hexrec_char_class u_class (
        .ch       (in_char),
        .nib      (nib),
        .is_hex   (is_hex),
        .is_colon (is_colon),
        .is_eol   (is_eol)
    );

    hexrec_parser u_parse (
        .clk      (clk),
        .rst      (rst),
        .take     (in_valid),
        .nib      (nib),
        .is_hex   (is_hex),
        .is_colon (is_colon),
        .is_eol   (is_eol),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .done     (done),
        .err      (error)
    );
endmodule

// File: rtl/hex_record_loader_chk.sv
module hex_record_loader_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic wr_en,
    input logic done,
    input logic error
);
    // R5: a write strobe never lasts two cycles
    p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R8: done holds once set
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R10: error holds once set
    p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    // R2: a write only follows a consumed character
    p_wr_after_char_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(in_valid));

    // R2: error only rises after a consumed character
    p_err_after_char_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> $past(in_valid));

    // R1: outputs are clear right after reset
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !error && !wr_en));
endmodule

bind hex_record_loader hex_record_loader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .wr_en    (wr_en),
    .done     (done),
    .error    (error)
);

// File: tb/tb_hex_record_loader.sv
module tb_hex_record_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_ready;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done;
    logic        error;

    always #5 clk = ~clk;

    hex_record_loader dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .error(error)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    int    cyc    = 0;
    bit    finished = 0;

    // reference model state
    bit m_in;
    int m_pos, m_len, m_addr, m_kind, m_sum, m_hi;
    bit e_wr, e_done, e_err;
    int e_addr, e_data;
    int dq[$];

    function automatic int hexval(logic [7:0] c);
        if (c >= "0" && c <= "9") return c - "0";
        if (c >= "A" && c <= "F") return c - "A" + 10;
        if (c >= "a" && c <= "f") return c - "a" + 10;
        return -1;
    endfunction

    function automatic logic [7:0] hexc(int n, bit lc);
        if (n < 10) return 8'(48 + n);
        return lc ? 8'(97 + n - 10) : 8'(65 + n - 10);
    endfunction

    task automatic model_clear();
        m_in = 0; m_pos = 0; m_sum = 0;
        e_wr = 0; e_done = 0; e_err = 0;
    endtask

    task automatic model(logic [7:0] c);
        int nv, b, bi;
        e_wr = 0;
        if (!m_in) begin
            if (c == 8'h3A) begin m_in = 1; m_pos = 0; m_sum = 0; end
            else if (c != 8'h0D && c != 8'h0A) e_err = 1;
            return;
        end
        nv = hexval(c);
        if (nv < 0) begin e_err = 1; m_in = 0; return; end
        m_pos++;
        if (m_pos % 2 == 1) begin m_hi = nv; return; end
        b  = m_hi * 16 + nv;
        m_sum = (m_sum + b) % 256;
        bi = m_pos / 2;
        if (bi == 1) m_len = b;
        else if (bi == 2) m_addr = b * 256;
        else if (bi == 3) m_addr = m_addr + b;
        else if (bi == 4) begin
            m_kind = b;
            if (b > 1) begin e_err = 1; m_in = 0; end
        end else if (bi <= 4 + m_len) begin
            if (m_kind == 0) begin
                e_wr = 1; e_addr = (m_addr + bi - 5) % 65536; e_data = b;
            end
        end else begin
            if (m_sum == 0) begin if (m_kind == 1) e_done = 1; end
            else e_err = 1;
            m_in = 0;
        end
    endtask

    task automatic compare();
        checks++;
        if (wr_en !== e_wr || (e_wr && (wr_addr !== 16'(e_addr) || wr_data !== 8'(e_data)))
            || done !== e_done || error !== e_err || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL %s: actual wr=%b addr=%h data=%h done=%b err=%b rdy=%b expected wr=%b addr=%h data=%h done=%b err=%b rdy=1",
                     tag, wr_en, wr_addr, wr_data, done, error, in_ready,
                     e_wr, 16'(e_addr), 8'(e_data), e_done, e_err);
        end
    endtask

    task automatic step(bit v, logic [7:0] c);
        compare();
        in_valid = v;
        in_char  = c;
        if (v) model(c); else e_wr = 0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; in_valid = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        model_clear();
    endtask

    task automatic send_byte(int b, bit lc, bit gap);
        step(1, hexc(b / 16, lc));
        if (gap) step(0, 8'h55);
        step(1, hexc(b % 16, lc));
    endtask

    task automatic send_record(int len, int addr, int kind, bit lc, int bad, bit gap);
        int s;
        s = len + addr / 256 + addr % 256 + kind;
        step(1, 8'h3A);
        send_byte(len, lc, gap);
        send_byte(addr / 256, lc, gap);
        send_byte(addr % 256, lc, gap);
        send_byte(kind, lc, gap);
        for (int i = 0; i < len; i++) begin
            send_byte(dq[i], lc, gap);
            s += dq[i];
        end
        send_byte(((256 - (s % 256)) % 256) ^ bad, lc, gap);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL R2 watchdog: actual run still busy, expected end before limit");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        tag = "R1"; step(0, 8'h00);

        tag = "R3"; dq = '{8'h11, 8'hA5, 8'h3C};
        send_record(3, 16'h1234, 0, 0, 0, 0);
        tag = "R4"; dq = '{8'hBE, 8'hEF};
        send_record(2, 16'h00F0, 0, 1, 0, 0);
        tag = "R2"; dq = '{8'h7E, 8'h81};
        send_record(2, 16'h4000, 0, 0, 0, 1);
        tag = "R5"; dq = '{8'h01, 8'h02, 8'h03, 8'h04};
        send_record(4, 16'hFFFE, 0, 0, 0, 0);
        tag = "R9"; step(1, 8'h0D); step(1, 8'h0A);
        dq = '{8'h5A}; send_record(1, 16'h0100, 0, 0, 0, 0);
        tag = "R5"; send_record(0, 16'h2000, 0, 0, 0, 0);
        tag = "R8"; dq = '{8'hAA, 8'h55};
        send_record(2, 16'h0000, 1, 0, 0, 0);
        step(0, 8'h00); step(0, 8'h00);

        do_reset();
        tag = "R1"; step(0, 8'h00);
        tag = "R6"; dq = '{8'h10, 8'h20};
        send_record(2, 16'h0300, 0, 0, 1, 0);
        tag = "R10"; dq = '{8'h33, 8'h44};
        send_record(2, 16'h0400, 0, 0, 0, 0);

        do_reset();
        tag = "R4"; step(1, 8'h3A); step(1, "1"); step(1, "2"); step(1, "G");
        dq = '{8'h99}; send_record(1, 16'h0500, 0, 0, 0, 0);
        do_reset();
        tag = "R4"; step(1, 8'h3A); step(1, "0"); step(1, 8'h3A);
        step(0, 8'h00);

        do_reset();
        tag = "R7"; send_record(0, 16'h0000, 2, 0, 0, 0);
        step(0, 8'h00);

        do_reset();
        tag = "R9"; step(1, "x"); step(0, 8'h00);

        do_reset();
        tag = "R8"; send_record(0, 16'h0000, 1, 0, 1, 0);
        send_record(0, 16'h0000, 1, 0, 0, 0);
        step(0, 8'h00);

        compare();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule